// File: doc/BRIEF.md
# Dimmer Mode Supervisor

This block keeps track of how a phase-cut wall dimmer in front of a lamp driver should be treated. It moves through a short discovery window, a startup blanking phase and then one of four running modes. All of its state advances on a strobe that marks each rectified AC half-cycle boundary. With each strobe the slope-measurement logic upstream presents three flags: whether a sharp slope was seen in the half-cycle just ended, whether that slope was rising (leading-edge cut) and whether it was falling (trailing-edge cut).

During discovery the block asks the power stage to place a resistive load across the dimmer, so the dimmer behaves as it would with an incandescent lamp and its cut type can be told apart. Discovery picks leading or trailing startup, and also notes when no dimmer was seen at all. During startup blanking every slope report is ignored, which rides out soft-start and self-adapting dimmers. After that the block follows the cut half-cycle by half-cycle. It drops into a zero-phase-cut submode whenever the cut disappears and returns when the cut comes back. It changes between the leading and trailing families only after an unbroken run of opposite-type cuts.

Top module: `dimmer_mode_sup`

## Requirements
- R1: A synchronous reset puts the block in discovery (mode code 0) with `loadEn` = 1 and `slopeMask` = 1. The mode codes are: 0 discovery, 1 startup-leading, 2 startup-trailing, 3 leading, 4 trailing, 5 leading zero-cut, 6 trailing zero-cut.
- R2: While `halfTick` is low, the mode and all outputs hold their values whatever the edge flags do.
- R3: `loadEn` is 1 exactly while the mode is discovery. Discovery lasts 4 strobes: after the 4th strobe the mode has left discovery.
- R4: A strobe carries a leading cut when `edgeSeen`=1 and `edgeLeading`=1. It carries a trailing cut when `edgeSeen`=1, `edgeTrailing`=1 and `edgeLeading`=0. Any other combination is no cut. If any of the 4 discovery strobes carried a leading cut, discovery exits to startup-leading (1). Otherwise it exits to startup-trailing (2).
- R5: Startup lasts 16 strobes, and edge flags during startup have no effect. `slopeMask` is 1 in discovery and both startup modes and 0 in every other mode.
- R6: Startup-leading exits to leading (3). Startup-trailing exits to trailing (4) if any discovery strobe carried a cut. If none did, it exits to trailing zero-cut (6).
- R7: In leading or leading zero-cut, a no-cut strobe gives leading zero-cut (5) and a leading-cut strobe gives leading (3). In trailing or trailing zero-cut, a no-cut strobe gives trailing zero-cut (6) and a trailing-cut strobe gives trailing (4).
- R8: An opposite-family cut leaves the mode unchanged until the 16th consecutive one. That strobe moves the leading family to trailing (4) and the trailing family to leading (3).
- R9: Any strobe without an opposite-family cut restarts the count of consecutive opposite cuts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| halfTick | input | 1 | One-cycle strobe at each AC half-cycle boundary |
| edgeSeen | input | 1 | A sharp slope occurred in the half-cycle just ended |
| edgeLeading | input | 1 | The slope was rising (leading-edge cut) |
| edgeTrailing | input | 1 | The slope was falling (trailing-edge cut) |
| mode | output | 3 | Current mode code (see R1) |
| loadEn | output | 1 | Requests a resistive load across the dimmer |
| slopeMask | output | 1 | Tells downstream logic to ignore slope reports |

## Verification
Each result is due one clock after the edge that samples a strobe. The mode is a single register, and `loadEn` and `slopeMask` are decoded from it with no further delay. The bench changes inputs on the falling clock edge and holds the strobe for exactly one cycle. It reads the outputs on the next falling edge, half a period after the register has updated. Windows of 4 and 16 strobes are checked after every strobe in the window, so a count that is off by one fails at the strobe where it goes wrong.

// File: rtl/dms_pkg.sv
package dms_pkg;

  typedef enum logic [2:0] {
    MD_DISCOVER    = 3'd0,
    MD_START_LEAD  = 3'd1,
    MD_START_TRAIL = 3'd2,
    MD_LEAD        = 3'd3,
    MD_TRAIL       = 3'd4,
    MD_LEAD_ZPC    = 3'd5,
    MD_TRAIL_ZPC   = 3'd6
  } mode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic phaseInc;
    logic phaseClr;
    logic oppInc;
    logic oppClr;
    logic discSample;
  } dp_ctl_t;

  // status from datapath to control
  typedef struct packed {
    logic phaseLastDisc;
    logic phaseLastBlank;
    logic oppLast;
    logic edgeLead;
    logic edgeTrail;
    logic discLead;
    logic discAny;
  } dp_stat_t;

endpackage

// File: rtl/dms_dpath.sv
module dms_dpath
  import dms_pkg::*;
#(
  parameter int DISC_HALVES   = 4,
  parameter int BLANK_HALVES  = 16,
  parameter int SWITCH_HALVES = 16
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     edgeSeen,
  input  logic     edgeLeading,
  input  logic     edgeTrailing,
  input  dp_ctl_t  ctl,
  output dp_stat_t stat
);

  localparam int PHASE_MAX = (DISC_HALVES > BLANK_HALVES) ? DISC_HALVES : BLANK_HALVES;
  localparam int PW = $clog2(PHASE_MAX + 1);
  localparam int OW = $clog2(SWITCH_HALVES + 1);

  logic [PW-1:0] phaseCnt;
  logic [OW-1:0] oppCnt;
  logic leadFlag, anyFlag;
  logic isLead, isTrail;

  // classification: leading wins when both direction flags are set
  assign isLead  = edgeSeen & edgeLeading;
  assign isTrail = edgeSeen & edgeTrailing & ~edgeLeading;

  always_ff @(posedge clk) begin
    if (rst)               phaseCnt <= '0;
    else if (ctl.phaseClr) phaseCnt <= '0;
    else if (ctl.phaseInc) phaseCnt <= phaseCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             oppCnt <= '0;
    else if (ctl.oppClr) oppCnt <= '0;
    else if (ctl.oppInc) oppCnt <= oppCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      leadFlag <= 1'b0;
      anyFlag  <= 1'b0;
    end else if (ctl.discSample) begin
      leadFlag <= leadFlag | isLead;
      anyFlag  <= anyFlag | isLead | isTrail;
    end
  end

  always_comb begin
    stat.phaseLastDisc  = (phaseCnt == PW'(DISC_HALVES - 1));
    stat.phaseLastBlank = (phaseCnt == PW'(BLANK_HALVES - 1));
    stat.oppLast        = (oppCnt == OW'(SWITCH_HALVES - 1));
    stat.edgeLead       = isLead;
    stat.edgeTrail      = isTrail;
    stat.discLead       = leadFlag | isLead;
    stat.discAny        = anyFlag;
  end

  // R5: window counter never runs past the longer window
  a_r5_phase_bound: assert property (@(posedge clk) disable iff (rst)
    phaseCnt < PW'(PHASE_MAX));

  // R8: the opposite run counter is cleared before it can reach the limit
  a_r8_opp_bound: assert property (@(posedge clk) disable iff (rst)
    oppCnt < OW'(SWITCH_HALVES));

  // R9: a strobe without an opposite cut leaves the run count at zero
  a_r9_opp_restart: assert property (@(posedge clk) disable iff (rst)
    ctl.oppClr |=> (oppCnt == '0));

endmodule

// File: rtl/dms_ctrl.sv
module dms_ctrl
  import dms_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     halfTick,
  input  dp_stat_t stat,
  output mode_e    mode,
  output dp_ctl_t  ctl
);

  mode_e modeQ, nextMode;
  mode_e normOwn, zpcOwn, normOther;
  logic  leadFam, ownHit, oppHit;

  always_comb begin
    leadFam   = (modeQ == MD_LEAD) || (modeQ == MD_LEAD_ZPC);
    ownHit    = leadFam ? stat.edgeLead  : stat.edgeTrail;
    oppHit    = leadFam ? stat.edgeTrail : stat.edgeLead;
    normOwn   = leadFam ? MD_LEAD     : MD_TRAIL;
    zpcOwn    = leadFam ? MD_LEAD_ZPC : MD_TRAIL_ZPC;
    normOther = leadFam ? MD_TRAIL    : MD_LEAD;
  end

  always_comb begin
    nextMode = modeQ;
    ctl      = '0;
    if (halfTick) begin
      case (modeQ)
        MD_DISCOVER: begin
          ctl.discSample = 1'b1;
          ctl.oppClr     = 1'b1;
          if (stat.phaseLastDisc) begin
            ctl.phaseClr = 1'b1;
            nextMode     = stat.discLead ? MD_START_LEAD : MD_START_TRAIL;
          end else begin
            ctl.phaseInc = 1'b1;
          end
        end
        MD_START_LEAD, MD_START_TRAIL: begin
          ctl.oppClr = 1'b1;
          if (stat.phaseLastBlank) begin
            ctl.phaseClr = 1'b1;
            if (modeQ == MD_START_LEAD) nextMode = MD_LEAD;
            else if (stat.discAny)      nextMode = MD_TRAIL;
            else                        nextMode = MD_TRAIL_ZPC;
          end else begin
            ctl.phaseInc = 1'b1;
          end
        end
        MD_LEAD, MD_TRAIL, MD_LEAD_ZPC, MD_TRAIL_ZPC: begin
          if (oppHit) begin
            if (stat.oppLast) begin
              ctl.oppClr = 1'b1;
              nextMode   = normOther;
            end else begin
              ctl.oppInc = 1'b1;
            end
          end else begin
            ctl.oppClr = 1'b1;
            nextMode   = ownHit ? normOwn : zpcOwn;
          end
        end
        default: begin
          ctl.phaseClr = 1'b1;
          ctl.oppClr   = 1'b1;
          nextMode     = MD_DISCOVER;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) modeQ <= MD_DISCOVER;
    else     modeQ <= nextMode;
  end

  assign mode = modeQ;

  // R2: no strobe, no mode change
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !halfTick |=> $stable(modeQ));

  // R4: discovery can only lead into a startup mode
  a_r4_disc_exit: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MD_DISCOVER) |=>
      (modeQ == MD_DISCOVER || modeQ == MD_START_LEAD || modeQ == MD_START_TRAIL));

  // R6: startup-leading only exits to leading
  a_r6_sle_exit: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MD_START_LEAD) |=> (modeQ == MD_START_LEAD || modeQ == MD_LEAD));

  // R6: startup-trailing only exits into the trailing family
  a_r6_ste_exit: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MD_START_TRAIL) |=>
      (modeQ == MD_START_TRAIL || modeQ == MD_TRAIL || modeQ == MD_TRAIL_ZPC));

  // R7: a leading cut in the leading family lands in leading mode
  a_r7_lead_back: assert property (@(posedge clk) disable iff (rst)
    (leadFam && halfTick && stat.edgeLead) |=> (modeQ == MD_LEAD));

  // R8: the leading family is left only on the final opposite strobe
  a_r8_lead_stay: assert property (@(posedge clk) disable iff (rst)
    (leadFam && !(halfTick && stat.edgeTrail && stat.oppLast)) |=>
      (modeQ == MD_LEAD || modeQ == MD_LEAD_ZPC));

endmodule

// File: rtl/dimmer_mode_sup.sv
module dimmer_mode_sup
  import dms_pkg::*;
#(
  parameter int DISC_HALVES   = 4,
  parameter int BLANK_HALVES  = 16,
  parameter int SWITCH_HALVES = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       halfTick,
  input  logic       edgeSeen,
  input  logic       edgeLeading,
  input  logic       edgeTrailing,
  output logic [2:0] mode,
  output logic       loadEn,
  output logic       slopeMask
);

  dp_ctl_t  ctl;
  dp_stat_t stat;
  mode_e    modeCur;

  dms_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .halfTick (halfTick),
    .stat     (stat),
    .mode     (modeCur),
    .ctl      (ctl)
  );

  dms_dpath #(
    .DISC_HALVES   (DISC_HALVES),
    .BLANK_HALVES  (BLANK_HALVES),
    .SWITCH_HALVES (SWITCH_HALVES)
  ) dpath_i (
    .clk          (clk),
    .rst          (rst),
    .edgeSeen     (edgeSeen),
    .edgeLeading  (edgeLeading),
    .edgeTrailing (edgeTrailing),
    .ctl          (ctl),
    .stat         (stat)
  );

  assign mode      = modeCur;
  assign loadEn    = (modeCur == MD_DISCOVER);
  assign slopeMask = (modeCur == MD_DISCOVER) || (modeCur == MD_START_LEAD) ||
                     (modeCur == MD_START_TRAIL);

  // R1: reset lands in discovery with the load requested
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mode == 3'd0 && loadEn && slopeMask));

  // R3: the load is only requested while slope reports are masked
  a_r3_load_masked: assert property (@(posedge clk) disable iff (rst)
    loadEn |-> slopeMask);

  // R5: masking drops only on a strobe
  a_r5_mask_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(slopeMask) |-> $past(halfTick));

endmodule

// File: tb/dimmer_mode_sup_tb_top.sv
module dimmer_mode_sup_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b0;
  logic halfTick = 1'b0;
  logic edgeSeen = 1'b0;
  logic edgeLeading = 1'b0;
  logic edgeTrailing = 1'b0;
  logic [2:0] mode;
  logic loadEn, slopeMask;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dimmer_mode_sup dut_i (
    .clk(clk), .rst(rst), .halfTick(halfTick),
    .edgeSeen(edgeSeen), .edgeLeading(edgeLeading), .edgeTrailing(edgeTrailing),
    .mode(mode), .loadEn(loadEn), .slopeMask(slopeMask)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 no cut, 1 leading, 2 trailing, 3 both direction flags, 4 seen without direction
  task automatic setKind(input int kind);
    edgeSeen     = (kind != 0);
    edgeLeading  = (kind == 1) || (kind == 3);
    edgeTrailing = (kind == 2) || (kind == 3);
  endtask

  task automatic hc(input int kind);
    @(negedge clk);
    setKind(kind);
    halfTick = 1'b1;
    @(negedge clk);
    halfTick = 1'b0;
    setKind(0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic toFamily(input int firstKind);
    doReset();
    hc(firstKind);
    for (int i = 0; i < 3; i++) hc(0);
    for (int i = 0; i < 16; i++) hc(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    check("R1 mode", mode, 0);
    check("R1 loadEn", loadEn, 1);
    check("R1 slopeMask", slopeMask, 1);

    // R2 edge flags without a strobe change nothing
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); setKind(k);
    end
    @(negedge clk); setKind(0);
    check("R2 mode held in discovery", mode, 0);
    check("R2 loadEn held", loadEn, 1);

    // R3..R6 exhaustive sweep over 3^4 discovery patterns
    for (int code = 0; code < 81; code++) begin
      bit anyLead = 0;
      bit anyCut = 0;
      int expStart;
      int expRun;
      int div = 1;
      doReset();
      check("R1 mode after reset", mode, 0);
      for (int i = 0; i < 4; i++) begin
        int d = (code / div) % 3;
        div = div * 3;
        if (d == 1) anyLead = 1;
        if (d != 0) anyCut = 1;
        hc(d);
        if (i < 3) begin
          check("R3 still discovering", mode, 0);
          check("R3 loadEn in discovery", loadEn, 1);
        end
      end
      expStart = anyLead ? 1 : 2;
      expRun   = anyLead ? 3 : (anyCut ? 4 : 6);
      check("R4 startup choice", mode, expStart);
      check("R3 loadEn after discovery", loadEn, 0);
      check("R5 mask in startup", slopeMask, 1);
      for (int j = 0; j < 16; j++) begin
        hc((j + code) % 5);
        if (j < 15) check("R5 startup ignores edges", mode, expStart);
      end
      check("R6 startup exit", mode, expRun);
      check("R5 mask cleared", slopeMask, 0);
    end

    // R4 both direction flags count as leading; seen without direction is no cut
    toFamily(3);
    check("R4 both flags is leading", mode, 3);
    toFamily(4);
    check("R4 seen without direction is no cut", mode, 6);

    // R7 zero-cut submodes
    toFamily(1);
    hc(0); check("R7 LE no cut", mode, 5);
    hc(4); check("R7 LEZPC no cut", mode, 5);
    hc(1); check("R7 LEZPC leading", mode, 3);
    hc(1); check("R7 LE leading", mode, 3);
    // R2 in running mode
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); setKind(k);
    end
    @(negedge clk); setKind(0);
    check("R2 mode held in LE", mode, 3);
    toFamily(2);
    check("R6 trailing start", mode, 4);
    hc(0); check("R7 TE no cut", mode, 6);
    hc(2); check("R7 TEZPC trailing", mode, 4);
    hc(1); check("R8 TE one opposite", mode, 4);

    // R8 run-length sweep in both families
    for (int n = 1; n <= 17; n++) begin
      toFamily(1);
      for (int k = 1; k <= n; k++) begin
        hc(2);
        check("R8 leading family opposite run", mode, (k >= 16) ? 4 : 3);
      end
      toFamily(2);
      for (int k = 1; k <= n; k++) begin
        hc(1);
        check("R8 trailing family opposite run", mode, (k >= 16) ? 3 : 4);
      end
    end

    // R8 from a zero-cut submode
    toFamily(1);
    hc(0);
    for (int k = 1; k <= 16; k++) begin
      hc(2);
      check("R8 LEZPC opposite run", mode, (k == 16) ? 4 : 5);
    end
    toFamily(2);
    hc(0);
    for (int k = 1; k <= 16; k++) begin
      hc(1);
      check("R8 TEZPC opposite run", mode, (k == 16) ? 3 : 6);
    end

    // R9 broken runs restart the count
    toFamily(1);
    for (int k = 0; k < 15; k++) hc(2);
    check("R9 run of 15", mode, 3);
    hc(0); check("R9 break to LEZPC", mode, 5);
    for (int k = 0; k < 15; k++) hc(2);
    check("R9 second run of 15", mode, 5);
    hc(2); check("R9 16th unbroken", mode, 4);

    toFamily(2);
    for (int k = 0; k < 15; k++) hc(1);
    hc(2); check("R9 own cut breaks run", mode, 4);
    for (int k = 0; k < 15; k++) hc(1);
    check("R9 trailing second run of 15", mode, 4);
    hc(1); check("R9 trailing 16th unbroken", mode, 3);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule